// File: doc/BRIEF.md
# LIN Break Generator and Detector

This block produces and recognises the long dominant (low) symbol that marks the start of a LIN frame on a UART-style serial port. On the transmit side, a one-cycle request pulls the serial output low for a selectable number of bit times. The output then returns to idle (high). On the receive side, the block watches the already-sampled serial input. It raises a sticky flag when the line has stayed low for a fixed run of bit times, and it can turn that flag into an interrupt.

All timing is counted in bit times. Bit times come as single-cycle ticks from a baud generator outside the block. Software sees one small control word holding three fields: interrupt enable, detected flag and break length. The flag is cleared by writing 0 to its bit. A read-modify-write access reads the flag as 1, so the write-back of such an access cannot clear it by accident. Byte framing, the baud generator and any FIFOs are outside this block.

Top module: `lin_brk_unit`

## Requirements
- R1: After reset the serial output is high, the detected flag and the interrupt are 0, and the control word reads all zero. The detected flag becomes 1 on the clock edge after the 13th consecutive tick at which the input is sampled low. Twelve consecutive low ticks do not set it.
- R2: The detection length is 13 bit times for every value of the length field.
- R3: A tick at which the input is sampled high restarts the low-run count from zero.
- R4: After a detection, the flag is not set again until a tick has sampled the input high. A line held low after a detection and a clear leaves the flag at 0.
- R5: The length field (control bits [1:0]) selects the generated break length. Values 00, 01, 10 and 11 give 13, 14, 15 and 16 ticks during which the output is low. The output goes low on the edge after the request, returns high on the edge of the last of those ticks, and stays high afterwards.
- R6: A break request that arrives while a break is already being generated is ignored and does not extend that break.
- R7: A register write with control bit [2] = 0 clears the detected flag and the interrupt. A write with bit [2] = 1 leaves the flag unchanged.
- R8: The interrupt output is 1 exactly when both the detected flag and the interrupt enable (control bit [3]) are 1.
- R9: While the read strobe is high, read data shows {enable, flag, length} in bits [3], [2] and [1:0]. During a read-modify-write read, bit [2] reads as 1 whatever the flag holds. With no read strobe, read data is zero.
- R10: Neither the detection count nor the generation count advances on cycles without a tick.
- R11: When a detection and a clearing write fall in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_tick_i | input | 1 | One-cycle pulse per bit time |
| rx_i | input | 1 | Sampled serial input |
| brk_req_i | input | 1 | Break request pulse |
| reg_wr_i | input | 1 | Control word write strobe |
| reg_rd_i | input | 1 | Control word read strobe |
| reg_rmw_i | input | 1 | Marks the current read as read-modify-write |
| wr_data_i | input | 4 | Write data {enable, flag, length[1:0]} |
| rd_data_o | output | 4 | Read data {enable, flag, length[1:0]} |
| tx_o | output | 1 | Serial output, high when idle |
| det_flag_o | output | 1 | Break detected flag |
| irq_o | output | 1 | Break interrupt |

## Verification
The hardest situations to reach are those where a detection lands in the same cycle as other register traffic. One is a detection on the very tick that carries a clearing write. Another is a line that stays low long after a detection, where a broken re-arm would set the flag a second time. Directed sequences first build a run of exactly twelve low ticks and then put the clearing write on the thirteenth. They also hold the line low for dozens of ticks around a clear. A random phase then drives long, sticky low runs while writes, read-modify-write reads and overlapping break requests arrive at random moments. A cycle-level reference model in the bench checks every output on every cycle.

// File: rtl/lin_brk_pkg.sv
package lin_brk_pkg;
    localparam int unsigned DET_BITS = 13;
    localparam int unsigned GEN_BASE = 13;
    localparam int unsigned LEN_W    = 2;
    localparam int unsigned CTR_W    = $clog2(GEN_BASE + (1 << LEN_W) + 1);
    localparam int unsigned CTRL_W   = LEN_W + 2;
    localparam int unsigned FLAG_POS = LEN_W;
    localparam int unsigned IE_POS   = LEN_W + 1;

    typedef logic [CTR_W-1:0] ctr_t;
    typedef logic [LEN_W-1:0] len_t;

    typedef struct packed {
        ctr_t cnt;
        logic armed;
    } rx_st_t;

    typedef struct packed {
        logic act;
        ctr_t cnt;
        ctr_t tgt;
    } tx_st_t;

    typedef struct packed {
        logic ie;
        logic flag;
        len_t len;
    } reg_st_t;
endpackage

// File: rtl/lin_brk_rx.sv
module lin_brk_rx
    import lin_brk_pkg::*;
#(
    parameter int unsigned RUN_BITS = DET_BITS
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic tick_i,
    input  logic rx_i,
    output logic det_set_o
);
    localparam ctr_t LAST = ctr_t'(RUN_BITS - 1);

    rx_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        det_set_o = 1'b0;
        if (tick_i) begin
            if (rx_i) begin
                st_d.cnt   = '0;
                st_d.armed = 1'b1;
            end else if (st_q.armed) begin
                if (st_q.cnt == LAST) begin
                    det_set_o  = 1'b1;
                    st_d.armed = 1'b0;
                    st_d.cnt   = '0;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.cnt   <= '0;
            st_q.armed <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/lin_brk_tx.sv
module lin_brk_tx
    import lin_brk_pkg::*;
#(
    parameter int unsigned BASE_BITS = GEN_BASE
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic tick_i,
    input  logic req_i,
    input  len_t len_i,
    output logic tx_o
);
    tx_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!st_q.act) begin
            if (req_i) begin
                st_d.act = 1'b1;
                st_d.cnt = '0;
                st_d.tgt = ctr_t'(BASE_BITS) + ctr_t'(len_i);
            end
        end else if (tick_i) begin
            if (st_q.cnt == st_q.tgt - 1'b1) begin
                st_d.act = 1'b0;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    assign tx_o = ~st_q.act;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/lin_brk_regs.sv
module lin_brk_regs
    import lin_brk_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_i,
    input  logic [CTRL_W-1:0] wd_i,
    input  logic              rd_i,
    input  logic              rmw_i,
    input  logic              det_set_i,
    output logic [CTRL_W-1:0] rd_data_o,
    output len_t              len_o,
    output logic              flag_o,
    output logic              irq_o
);
    reg_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_i) begin
            st_d.ie  = wd_i[IE_POS];
            st_d.len = wd_i[LEN_W-1:0];
            if (!wd_i[FLAG_POS]) begin
                st_d.flag = 1'b0;
            end
        end
        if (det_set_i) begin
            st_d.flag = 1'b1;
        end
    end

    always_comb begin
        rd_data_o = '0;
        if (rd_i) begin
            rd_data_o = {st_q.ie, st_q.flag | rmw_i, st_q.len};
        end
    end

    assign len_o  = st_q.len;
    assign flag_o = st_q.flag;
    assign irq_o  = st_q.flag & st_q.ie;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/lin_brk_unit.sv
module lin_brk_unit
    import lin_brk_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              bit_tick_i,
    input  logic              rx_i,
    input  logic              brk_req_i,
    input  logic              reg_wr_i,
    input  logic              reg_rd_i,
    input  logic              reg_rmw_i,
    input  logic [CTRL_W-1:0] wr_data_i,
    output logic [CTRL_W-1:0] rd_data_o,
    output logic              tx_o,
    output logic              det_flag_o,
    output logic              irq_o
);
    logic det_set;
    len_t len_sel;

    lin_brk_rx #(.RUN_BITS(DET_BITS)) rx_i0 (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .tick_i    (bit_tick_i),
        .rx_i      (rx_i),
        .det_set_o (det_set)
    );

    lin_brk_tx #(.BASE_BITS(GEN_BASE)) tx_i0 (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .tick_i (bit_tick_i),
        .req_i  (brk_req_i),
        .len_i  (len_sel),
        .tx_o   (tx_o)
    );

    lin_brk_regs regs_i0 (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_i      (reg_wr_i),
        .wd_i      (wr_data_i),
        .rd_i      (reg_rd_i),
        .rmw_i     (reg_rmw_i),
        .det_set_i (det_set),
        .rd_data_o (rd_data_o),
        .len_o     (len_sel),
        .flag_o    (det_flag_o),
        .irq_o     (irq_o)
    );
endmodule

// File: rtl/lin_brk_chk.sv
module lin_brk_chk
    import lin_brk_pkg::*;
(
    input logic              clk_i,
    input logic              rst_ni,
    input logic              bit_tick_i,
    input logic              rx_i,
    input logic              reg_wr_i,
    input logic              reg_rd_i,
    input logic              reg_rmw_i,
    input logic [CTRL_W-1:0] wr_data_i,
    input logic [CTRL_W-1:0] rd_data_o,
    input logic              tx_o,
    input logic              det_flag_o,
    input logic              irq_o,
    input logic              det_set
);
    // R8
    irq_needs_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> det_flag_o);

    // R7
    clear_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_wr_i && !wr_data_i[FLAG_POS] && !det_set) |=> (!det_flag_o && !irq_o));

    // R7
    write_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_wr_i && wr_data_i[FLAG_POS] && !det_flag_o && !det_set) |=> !det_flag_o);

    // R11
    set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        det_set |=> det_flag_o);

    // R9
    rmw_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_rd_i && reg_rmw_i) |-> rd_data_o[FLAG_POS]);

    // R1
    detect_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        det_set |-> (!rx_i && bit_tick_i));

    // R10
    hold_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!bit_tick_i && !tx_o) |=> !tx_o);

    // R10
    rise_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(det_flag_o) |-> $past(bit_tick_i));
endmodule

bind lin_brk_unit lin_brk_chk chk_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bit_tick_i (bit_tick_i),
    .rx_i       (rx_i),
    .reg_wr_i   (reg_wr_i),
    .reg_rd_i   (reg_rd_i),
    .reg_rmw_i  (reg_rmw_i),
    .wr_data_i  (wr_data_i),
    .rd_data_o  (rd_data_o),
    .tx_o       (tx_o),
    .det_flag_o (det_flag_o),
    .irq_o      (irq_o),
    .det_set    (det_set)
);

// File: tb/lin_brk_unit_tb_top.sv
module lin_brk_unit_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0, rx = 1'b1, req = 1'b0, wr = 1'b0, rd = 1'b0, rmw = 1'b0;
    logic [3:0] wd = '0;
    logic [3:0] rdata;
    logic tx, flag, irq;

    int checks = 0;
    int errors = 0;
    int lowticks = 0;
    logic cur_rx = 1'b1;

    // reference model state
    logic m_flag = 0, m_ie = 0, m_gact = 0, m_armed = 1;
    logic [1:0] m_len = 0;
    int m_cnt = 0, m_gcnt = 0, m_gtgt = 0;

    always #5 clk = ~clk;

    lin_brk_unit dut_i (
        .clk_i(clk), .rst_ni(rst_n), .bit_tick_i(tick), .rx_i(rx),
        .brk_req_i(req), .reg_wr_i(wr), .reg_rd_i(rd), .reg_rmw_i(rmw),
        .wr_data_i(wd), .rd_data_o(rdata), .tx_o(tx),
        .det_flag_o(flag), .irq_o(irq)
    );

    task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [3:0] exp_read(input logic rmw_v);
        return {m_ie, m_flag | rmw_v, m_len};
    endfunction

    task automatic model_adv(input logic tk, rxv, rq, w, input logic [3:0] d);
        logic set;
        if (!m_gact && rq) begin
            m_gact = 1; m_gcnt = 0; m_gtgt = 13 + int'(m_len);
        end else if (m_gact && tk) begin
            if (m_gcnt == m_gtgt - 1) m_gact = 0;
            else m_gcnt++;
        end
        set = 0;
        if (tk) begin
            if (rxv) begin
                m_cnt = 0; m_armed = 1;
            end else if (m_armed) begin
                if (m_cnt == 12) begin
                    set = 1; m_armed = 0; m_cnt = 0;
                end else m_cnt++;
            end
        end
        if (w) begin
            m_ie = d[3]; m_len = d[1:0];
            if (!d[2]) m_flag = 0;
        end
        if (set) m_flag = 1;
    endtask

    task automatic compare();
        check("R5 tx", {3'b0, tx}, {3'b0, !m_gact});
        check("R1 flag", {3'b0, flag}, {3'b0, m_flag});
        check("R8 irq", {3'b0, irq}, {3'b0, m_flag & m_ie});
    endtask

    task automatic cyc(input logic tk, rxv, rq, w, input logic [3:0] d, input logic r, rm);
        tick = tk; rx = rxv; req = rq; wr = w; wd = d; rd = r; rmw = rm;
        #1;
        if (tk && !tx) lowticks++;
        if (r) check("R9 read", rdata, exp_read(rm));
        else check("R9 idle read", rdata, 4'h0);
        model_adv(tk, rxv, rq, w, d);
        @(negedge clk);
        compare();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, cur_rx, 0, 0, 4'h0, 0, 0);
    endtask

    task automatic ticks(input int n, input logic v);
        cur_rx = v;
        for (int i = 0; i < n; i++) begin
            idle(3);
            cyc(1, cur_rx, 0, 0, 4'h0, 0, 0);
        end
    endtask

    task automatic wreg(input logic [3:0] d);
        cyc(0, cur_rx, 0, 1, d, 0, 0);
    endtask

    task automatic brk();
        cyc(0, cur_rx, 1, 0, 4'h0, 0, 0);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 reset tx", {3'b0, tx}, 4'h1);
        check("R1 reset flag", {3'b0, flag}, 4'h0);
        check("R8 reset irq", {3'b0, irq}, 4'h0);
        cyc(0, 1, 0, 0, 4'h0, 1, 0);

        // R1 twelve lows do not detect, thirteenth does
        ticks(12, 0);
        check("R1 twelve lows", {3'b0, flag}, 4'h0);
        ticks(1, 0);
        check("R1 thirteenth low", {3'b0, flag}, 4'h1);
        // R7 writing 1 keeps flag, R8 irq follows enable
        wreg(4'b1100);
        check("R7 write one", {3'b0, flag}, 4'h1);
        check("R8 irq on", {3'b0, irq}, 4'h1);
        ticks(20, 0);
        wreg(4'b1000);
        check("R7 clear flag", {3'b0, flag}, 4'h0);
        check("R7 clear irq", {3'b0, irq}, 4'h0);
        // R4 still low: no re-detection
        ticks(30, 0);
        check("R4 no rearm", {3'b0, flag}, 4'h0);
        ticks(1, 1);

        // R2 length field does not change detection
        wreg(4'b0011);
        ticks(12, 0);
        check("R2 twelve lows len3", {3'b0, flag}, 4'h0);
        ticks(1, 0);
        check("R2 detect len3", {3'b0, flag}, 4'h1);
        ticks(1, 1);
        wreg(4'b0000);

        // R3 high sample restarts count
        ticks(12, 0);
        ticks(1, 1);
        ticks(12, 0);
        check("R3 restarted", {3'b0, flag}, 4'h0);
        ticks(1, 0);
        check("R3 detect after restart", {3'b0, flag}, 4'h1);
        // R9 rmw read shows 1, normal read true value after clear
        wreg(4'b0000);
        ticks(1, 1);
        cyc(0, cur_rx, 0, 0, 4'h0, 1, 1);
        check("R9 rmw read", {3'b0, rdata[2]}, 4'h1);
        cyc(0, cur_rx, 0, 0, 4'h0, 1, 0);
        check("R9 plain read", {3'b0, rdata[2]}, 4'h0);

        // R10 no ticks: no detection
        cur_rx = 0;
        idle(100);
        check("R10 no tick no detect", {3'b0, flag}, 4'h0);
        ticks(1, 1);

        // R5 generation lengths
        for (int l = 0; l < 4; l++) begin
            wreg(4'(l));
            lowticks = 0;
            brk();
            check("R5 low after req", {3'b0, tx}, 4'h0);
            ticks(20, 1);
            check("R5 break length", 4'(lowticks), 4'(13 + l));
            check("R6 idle after", {3'b0, tx}, 4'h1);
        end
        // R10 break holds without ticks
        brk();
        idle(50);
        check("R10 break holds", {3'b0, tx}, 4'h0);
        ticks(20, 1);

        // R6 request during break ignored
        wreg(4'b0000);
        lowticks = 0;
        brk();
        ticks(5, 1);
        brk();
        ticks(20, 1);
        check("R6 not extended", 4'(lowticks), 4'd13);

        // R11 set wins over clear
        ticks(12, 0);
        cyc(1, 0, 0, 1, 4'b0000, 0, 0);
        check("R11 set wins", {3'b0, flag}, 4'h1);
        ticks(1, 1);
        wreg(4'b0000);

        // random phase
        for (int i = 0; i < 6000; i++) begin
            logic tk, rq, w, r, rm;
            logic [3:0] d;
            if ($urandom_range(0, 40) == 0) cur_rx = ~cur_rx;
            tk = ($urandom_range(0, 3) == 0);
            rq = ($urandom_range(0, 150) == 0);
            w  = ($urandom_range(0, 60) == 0);
            r  = ($urandom_range(0, 8) == 0);
            rm = r && $urandom_range(0, 1);
            d  = 4'($urandom);
            cyc(tk, cur_rx, rq, w, d, r, rm);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule